// File: doc/BRIEF.md
# Two-Key Write-Protect Gate

This block sits between a register bus and a peripheral register file and decides, write by write, whether a store may reach the registers. It starts closed. Software opens it by storing one 32-bit magic word to a first key address and then, as the very next write, a second magic word to a second key address. Any write of a wrong value to either key address (zero is the usual choice) closes it again. While the gate is closed, every write aimed at a protected address is discarded without an error; reads are never held back.

The gate has three states: closed, armed (first key seen) and open. It gives the downstream register file a write-enable qualifier for the current cycle and reports whether the gate is open. Key addresses are not backed by storage. A write to a key address is always taken by the gate and never passed on, and a read of a key address is flagged so that the read mux returns zero.

Top module: `key_write_gate`

## Requirements
- R1: After reset the gate is closed: `unlocked` is 0, and a write to a protected address gives `wr_pass` 0.
- R2: The first key sits at address 0x6C with value 0x83E70B13, and the second sits at address 0x70 with value 0x95A4F1E0. A correct first-key write followed directly by a correct second-key write raises `unlocked` in the cycle after the second write.
- R3: A correct second-key write that does not directly follow a correct first-key write leaves the gate closed. Any write to a protected address between the two keys cancels the armed state. Idle cycles and reads do not cancel it.
- R4: A write of any value other than the expected one to either key address, zero included, returns the gate to closed from any state, effective the next cycle.
- R5: While `unlocked` is 0, `wr_pass` is 0 for every write.
- R6: While `unlocked` is 1, `wr_pass` equals `wr_en` for every non-key address, and the gate stays open until a wrong key value is written.
- R7: A write to a key address never raises `wr_pass`. A read with `rd_en` high at a key address raises `rd_zero` in the same cycle. `rd_zero` is 0 for any other read.
- R8: While open, a correct first-key or second-key write leaves the gate open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the bus |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe from the bus |
| rd_addr | input | ADDR_W (8) | Byte address of the read |
| wr_pass | output | 1 | Write enable qualifier for the register file, this cycle |
| rd_zero | output | 1 | Read targets a key address; return zero |
| unlocked | output | 1 | Gate is open |

## Verification
The bench targets these sequencing corners:
- A second key with no first key before it. A design that ignored order would open here.
- A first key, then a protected write, then the second key. A design that only remembered the first key would open after the stray write.
- A first key, then idle cycles and key reads, then the second key. A design that dropped the armed state too eagerly would stay shut.
- Zero or corrupted key values written while open. A design that relocked only on zero would miss the corrupted-value case.
- Correct keys repeated while open. A design that relocked on them would cut off the register writes that follow.

Key-address writes are also checked to confirm they never leak through as register writes.

// File: rtl/key_write_gate.sv
module key_write_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY_A_VAL  = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY_B_VAL  = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_pass,
  output logic              rd_zero,
  output logic              unlocked
);

  typedef enum logic [1:0] {SHUT = 2'd0, ARMED = 2'd1, OPEN = 2'd2} gate_t;

  gate_t st, nxt;

  logic hit_a, hit_b, good_a, good_b, key_wr;

  assign hit_a  = wr_en && (wr_addr == KEY_A_ADDR);
  assign hit_b  = wr_en && (wr_addr == KEY_B_ADDR);
  assign good_a = (wr_data == KEY_A_VAL);
  assign good_b = (wr_data == KEY_B_VAL);
  assign key_wr = hit_a || hit_b;

  always_comb begin
    nxt = st;
    if (hit_a)
      nxt = !good_a ? SHUT : ((st == OPEN) ? OPEN : ARMED);
    else if (hit_b)
      nxt = !good_b ? SHUT : ((st == SHUT) ? SHUT : OPEN);
    else if (wr_en && st == ARMED)
      nxt = SHUT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SHUT;
    else        st <= nxt;
  end

  assign unlocked = (st == OPEN);
  assign wr_pass  = wr_en && !key_wr && unlocked;
  assign rd_zero  = rd_en && (rd_addr == KEY_A_ADDR || rd_addr == KEY_B_ADDR);

  // R2
  open_needs_key_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(hit_b && good_b));

  // R3
  stay_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !(hit_b && good_b)) |=> !unlocked);

  // R4
  bad_key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_a && !good_a) || (hit_b && !good_b)) |=> (!unlocked && st == SHUT));

  // R6
  stay_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !(hit_a && !good_a) && !(hit_b && !good_b)) |=> unlocked);

  // R7
  key_no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |-> !wr_pass);

endmodule

// File: tb/key_write_gate_bench.sv
module key_write_gate_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic wr_pass, rd_zero, unlocked;

  localparam logic [7:0]  KA = 8'h6C, KB = 8'h70;
  localparam logic [31:0] VA = 32'h83E70B13, VB = 32'h95A4F1E0;

  int checks = 0, errors = 0;
  int mst = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  key_write_gate u_key_write_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_pass(wr_pass), .rd_zero(rd_zero),
    .unlocked(unlocked));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit we, input logic [7:0] wa,
                      input logic [31:0] wd, input bit re, input logic [7:0] ra);
    bit iskey;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    #1;
    iskey = (wa == KA) || (wa == KB);
    chk({tag, " unlocked"}, unlocked, mst == 2);
    chk({tag, " wr_pass"}, wr_pass, we && !iskey && mst == 2);
    chk({tag, " rd_zero"}, rd_zero, re && (ra == KA || ra == KB));
    @(posedge clk);
    if (we) begin
      if (wa == KA)      mst = (wd != VA) ? 0 : (mst == 2 ? 2 : 1);
      else if (wa == KB) mst = (wd != VB) ? 0 : (mst == 0 ? 0 : 2);
      else if (mst == 1) mst = 0;
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 8'h00, 32'h0, 0, 8'h00);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset unlocked", unlocked, 0);
    rst_n = 1;
    mst = 0;
    // R1: protected write right after reset is dropped
    step("R1", 1, 8'h10, 32'h55, 0, 0);
    step("R5", 1, 8'h40, 32'h1, 0, 0);
    // R2: correct sequence opens
    step("R2", 1, KA, VA, 0, 0);
    step("R2", 1, KB, VB, 0, 0);
    idle("R2");
    // R6: writes pass while open
    step("R6", 1, 8'h00, 32'h12, 0, 0);
    step("R6", 1, 8'h98, 32'h1, 1, 8'h44);
    // R7: key reads flagged, key writes never pass
    step("R7", 0, 0, 0, 1, KA);
    step("R7", 0, 0, 0, 1, KB);
    // R8: correct keys while open keep it open
    step("R8", 1, KA, VA, 0, 0);
    step("R8", 1, 8'h20, 32'h7, 0, 0);
    step("R8", 1, KB, VB, 0, 0);
    step("R8", 1, 8'h24, 32'h9, 0, 0);
    // R4: zero to key relocks
    step("R4", 1, KA, 32'h0, 0, 0);
    step("R4", 1, 8'h24, 32'h9, 0, 0);
    // R3: second key alone does nothing
    step("R3", 1, KB, VB, 0, 0);
    step("R3", 1, 8'h08, 32'h3, 0, 0);
    // R3: protected write between keys cancels
    step("R3", 1, KA, VA, 0, 0);
    step("R3", 1, 8'h08, 32'h3, 0, 0);
    step("R3", 1, KB, VB, 0, 0);
    idle("R3");
    // R3: idle and reads between keys keep it armed
    step("R3", 1, KA, VA, 0, 0);
    idle("R3");
    step("R3", 0, 0, 0, 1, KA);
    step("R3", 1, KB, VB, 0, 0);
    idle("R3");
    // R4: corrupted second key while open relocks
    step("R4", 1, KB, VB ^ 32'h1, 0, 0);
    step("R4", 1, 8'h30, 32'h1, 0, 0);
    // R4: wrong first key, then second key stays closed
    step("R4", 1, KA, VA ^ 32'h8000_0000, 0, 0);
    step("R4", 1, KB, VB, 0, 0);
    idle("R4");
    // R2: keys in reverse order do not open
    step("R2", 1, KB, VB, 0, 0);
    step("R2", 1, KA, VA, 0, 0);
    idle("R2");
    step("R2", 1, KA, 32'h0, 0, 0);
    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: begin a = KA; d = lfsr[3] ? VA : {16'h0, lfsr}; end
        3'd2, 3'd3: begin a = KB; d = lfsr[4] ? VB : 32'h0; end
        default:    begin a = {lfsr[9:5], 3'b000}; d = {16'h0, lfsr}; end
      endcase
      step("R6 mixed", lfsr[7] | lfsr[8], a, d, lfsr[11], lfsr[1] ? KB : 8'h14);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule